// File: doc/BRIEF.md
# Low-Frequency Tag Command Responder

This block is the command layer of a low-frequency transponder. A physical-layer receiver sits in front of it. That receiver hands over each decoded reader frame as a bit count plus the leading 32 received bits, with the first bit on the air at the most significant position. The responder sorts the frame by its length, checks the redundant complemented fields of command frames, and answers from a bank of twelve 32-bit sectors. The answer can be the sector-0 identifier, a sector read, an inverted sector read, a write acknowledge, or the answer to a password exchange.

Writes take two frames. First a 10-bit write command arrives. The block echoes it and remembers the target sector. The next 32-bit frame is then stored into that sector without any reply. A side port lets the sector bank be preloaded before or between exchanges. Frame lengths up to `MAX_BITS` are accepted. Any length that carries no command is taken and dropped silently.

Both frame interfaces use valid/ready. A frame moves on a clock edge where `frm_valid` and `frm_ready` are both high. `frm_ready` is low while a reply is pending, so a reply that has not been taken back-pressures the receiver. A reply is presented on `rsp_valid` on the cycle after its frame was accepted. The data and length are held unchanged until an edge with `rsp_ready` high.

Top module: `lf_tag_responder`

## Requirements
- R1: After reset all sectors read as zero, the block is not in the writing state, `rsp_valid` is 0 and `frm_ready` is 1.
- R2: A 5-bit frame whose bits, first to last, are 1,1,0,0,0 is answered with sector 0, 32 bits long. Any other 5-bit frame gets no reply.
- R3: A 10-bit frame has this layout, first bit first: a 2-bit opcode, a 3-bit sector number, a 2-bit opcode complement, and a 3-bit sector complement (frm_word[24:22]). The frame is dropped with no reply unless the sector complement is the bitwise inverse of the sector number.
- R4: Opcode 11 with complement 00 answers with the addressed sector, 32 bits long.
- R5: Opcode 01 with complement 10 answers with the bitwise inverse of the addressed sector, 32 bits long.
- R6: Opcode 10 with complement 01 answers with the 10 received bits, left-aligned in `rsp_bits` with zeros below and `rsp_len` of 10. It latches the sector number and enters the writing state.
- R7: In the writing state the next 32-bit frame is stored in the latched sector, produces no reply, and returns the block to idle. Frames of any other length leave the writing state in place.
- R8: A 32-bit frame received while idle is compared with sector 1. If it matches, the reply is sector 3, 32 bits long. Otherwise there is no reply.
- R9: Opcode pairs other than the three above, and frames of any length other than 5, 10 or 32 (64 included), produce no reply and do not change the state.
- R10: A reply appears on `rsp_valid` in the cycle after its frame is accepted. Data and length stay stable until `rsp_ready`, and while a reply waits `frm_ready` is 0.
- R11: `pl_we` writes `pl_data` into sector `pl_addr` at the next edge. Addresses 12 and above are ignored. A protocol write to the same sector in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A decoded frame is offered |
| frm_ready | output | 1 | Frame can be accepted (no reply pending) |
| frm_len | input | 8 | Frame length in bits (0..MAX_BITS) |
| frm_word | input | 32 | Leading frame bits, first received bit at bit 31 |
| rsp_valid | output | 1 | Reply is presented |
| rsp_ready | input | 1 | Consumer takes the reply |
| rsp_len | output | 6 | Reply length in bits (10 or 32) |
| rsp_bits | output | 32 | Reply bits, first bit to send at bit 31 |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 4 | Preload sector index |
| pl_data | input | 32 | Preload sector value |

## Verification
The bench uses the default parameters: twelve sectors and a 160-bit frame limit. This gives an 8-bit length field and a 4-bit preload index. With that index, writes to the nonexistent sectors 12 to 15 can be offered, and the bench checks that they leave the readable sectors untouched. All eight sector numbers that a command frame can name lie inside the bank, so reads at the top number (7) and writes to sectors 0 and 6 are checked. A 64-bit frame can be presented inside the length limit and shown to have no effect on a pending write.

// File: rtl/lft_pkg.sv
package lft_pkg;

  localparam int WORD_W   = 32;
  localparam int UID_LEN  = 5;
  localparam int CMD_LEN  = 10;
  localparam int AUTH_LEN = 64;
  localparam logic [UID_LEN-1:0] UID_CODE = 5'b11000;

  typedef enum logic [2:0] {
    CLS_UID,
    CLS_CMD,
    CLS_WORD,
    CLS_AUTH,
    CLS_OTHER
  } len_cls_e;

  typedef enum logic [1:0] {
    OP_READ,
    OP_INV,
    OP_WRITE,
    OP_BAD
  } op_e;

  typedef enum logic {
    ST_IDLE,
    ST_WRITING
  } tag_state_e;

  typedef struct packed {
    len_cls_e   cls;
    logic       uid_ok;
    logic       chk_ok;
    op_e        op;
    logic [2:0] sect;
  } dec_t;

endpackage

// File: rtl/lft_sector_store.sv
module lft_sector_store #(
  parameter int NUM_SECT = 12,
  parameter int DATA_W   = 32,
  localparam int SA_W    = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_we,
  input  logic [SA_W-1:0]   pl_addr,
  input  logic [DATA_W-1:0] pl_data,
  input  logic              pw_we,
  input  logic [SA_W-1:0]   pw_addr,
  input  logic [DATA_W-1:0] pw_data,
  input  logic [SA_W-1:0]   rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [SA_W-1:0]   rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [DATA_W-1:0] mem [NUM_SECT];

  // Protocol write beats preload on the same sector; out-of-range indices match nothing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SECT; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SECT; i++) begin
        if (pw_we && pw_addr == SA_W'(i))      mem[i] <= pw_data;
        else if (pl_we && pl_addr == SA_W'(i)) mem[i] <= pl_data;
      end
    end
  end

  always_comb begin
    rd_a_data = '0;
    rd_b_data = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (rd_a_addr == SA_W'(i)) rd_a_data = mem[i];
      if (rd_b_addr == SA_W'(i)) rd_b_data = mem[i];
    end
  end

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_hold
    // R11: a sector changes only when one of the two write ports addresses it
    assert_sector_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(pl_we && pl_addr == SA_W'(g)) && !(pw_we && pw_addr == SA_W'(g))
      |=> $stable(mem[g]));
  end

endmodule

// File: rtl/lft_cmd_decode.sv
module lft_cmd_decode
  import lft_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [LEN_W-1:0]   frm_len,
  input  logic [CMD_LEN-1:0] head,
  output dec_t               dec
);

  logic [1:0] opc, opc_n;
  logic [2:0] sec, sec_n;

  assign opc   = head[9:8];
  assign sec   = head[7:5];
  assign opc_n = head[4:3];
  assign sec_n = head[2:0];

  always_comb begin
    if (frm_len == LEN_W'(UID_LEN))       dec.cls = CLS_UID;
    else if (frm_len == LEN_W'(CMD_LEN))  dec.cls = CLS_CMD;
    else if (frm_len == LEN_W'(WORD_W))   dec.cls = CLS_WORD;
    else if (frm_len == LEN_W'(AUTH_LEN)) dec.cls = CLS_AUTH;
    else                                  dec.cls = CLS_OTHER;

    dec.uid_ok = (head[CMD_LEN-1 -: UID_LEN] == UID_CODE);
    dec.chk_ok = (sec_n == ~sec);
    dec.sect   = sec;

    case ({opc, opc_n})
      4'b1100: dec.op = OP_READ;
      4'b0110: dec.op = OP_INV;
      4'b1001: dec.op = OP_WRITE;
      default: dec.op = OP_BAD;
    endcase
  end

  always_comb begin
    // R3: a frame reported as checked must carry complementary sector fields
    assert_check_pair_R3: assert (!dec.chk_ok || ((sec ^ sec_n) == 3'b111));
  end

endmodule

// File: rtl/lft_resp_ctrl.sv
module lft_resp_ctrl
  import lft_pkg::*;
#(
  parameter int NUM_SECT = 12,
  localparam int SA_W    = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int RL_W    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [WORD_W-1:0] frm_word,
  input  dec_t              dec,
  output logic [SA_W-1:0]   rd_a_addr,
  input  logic [WORD_W-1:0] rd_a_data,
  input  logic [WORD_W-1:0] rd_b_data,
  output logic              pw_we,
  output logic [SA_W-1:0]   pw_addr,
  output logic [WORD_W-1:0] pw_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RL_W-1:0]   rsp_len,
  output logic [WORD_W-1:0] rsp_bits
);

  tag_state_e        st, st_nx;
  logic [2:0]        wsec, wsec_nx;
  logic              acc;
  logic              give;
  logic [RL_W-1:0]   give_len;
  logic [WORD_W-1:0] give_bits;

  assign frm_ready = !rsp_valid;
  assign acc       = frm_valid && frm_ready;

  always_comb begin
    case (dec.cls)
      CLS_CMD:  rd_a_addr = SA_W'(dec.sect);
      CLS_WORD: rd_a_addr = SA_W'(3);
      default:  rd_a_addr = '0;
    endcase
  end

  always_comb begin
    st_nx     = st;
    wsec_nx   = wsec;
    give      = 1'b0;
    give_len  = RL_W'(WORD_W);
    give_bits = rd_a_data;
    pw_we     = 1'b0;
    pw_addr   = SA_W'(wsec);
    pw_data   = frm_word;
    if (acc) begin
      case (dec.cls)
        CLS_UID: give = dec.uid_ok;
        CLS_CMD: begin
          if (dec.chk_ok) begin
            case (dec.op)
              OP_READ: give = 1'b1;
              OP_INV: begin
                give      = 1'b1;
                give_bits = ~rd_a_data;
              end
              OP_WRITE: begin
                give      = 1'b1;
                give_len  = RL_W'(CMD_LEN);
                give_bits = {frm_word[WORD_W-1 -: CMD_LEN], {(WORD_W-CMD_LEN){1'b0}}};
                st_nx     = ST_WRITING;
                wsec_nx   = dec.sect;
              end
              default: give = 1'b0;
            endcase
          end
        end
        CLS_WORD: begin
          if (st == ST_WRITING) begin
            pw_we = 1'b1;
            st_nx = ST_IDLE;
          end else begin
            give = (frm_word == rd_b_data);
          end
        end
        default: give = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wsec      <= '0;
      rsp_valid <= 1'b0;
      rsp_len   <= '0;
      rsp_bits  <= '0;
    end else begin
      st   <= st_nx;
      wsec <= wsec_nx;
      if (give) begin
        rsp_valid <= 1'b1;
        rsp_len   <= give_len;
        rsp_bits  <= give_bits;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_bits) && $stable(rsp_len));

  assert_rsp_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_len == RL_W'(WORD_W)) || (rsp_len == RL_W'(CMD_LEN)));

  assert_echo_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_len == RL_W'(CMD_LEN) |-> st == ST_WRITING);

  assert_data_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && dec.cls == CLS_WORD && st == ST_WRITING |=> st == ST_IDLE && !rsp_valid);

  assert_bad_check_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && dec.cls == CLS_CMD && !dec.chk_ok |=> !rsp_valid && $stable(st));

  assert_auth_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && dec.cls == CLS_AUTH |=> !rsp_valid && $stable(st) && $stable(wsec));

endmodule

// File: rtl/lf_tag_responder.sv
module lf_tag_responder
  import lft_pkg::*;
#(
  parameter int NUM_SECT = 12,
  parameter int MAX_BITS = 160,
  localparam int LEN_W   = $clog2(MAX_BITS + 1),
  localparam int SA_W    = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int RL_W    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [WORD_W-1:0] frm_word,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RL_W-1:0]   rsp_len,
  output logic [WORD_W-1:0] rsp_bits,
  input  logic              pl_we,
  input  logic [SA_W-1:0]   pl_addr,
  input  logic [WORD_W-1:0] pl_data
);

  dec_t              dec;
  logic [SA_W-1:0]   rd_a_addr;
  logic [WORD_W-1:0] rd_a_data, rd_b_data;
  logic              pw_we;
  logic [SA_W-1:0]   pw_addr;
  logic [WORD_W-1:0] pw_data;

  lft_cmd_decode #(.LEN_W(LEN_W)) u_dec (
    .frm_len (frm_len),
    .head    (frm_word[WORD_W-1 -: CMD_LEN]),
    .dec     (dec)
  );

  lft_sector_store #(.NUM_SECT(NUM_SECT), .DATA_W(WORD_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .pl_we     (pl_we),
    .pl_addr   (pl_addr),
    .pl_data   (pl_data),
    .pw_we     (pw_we),
    .pw_addr   (pw_addr),
    .pw_data   (pw_data),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_addr (SA_W'(1)),
    .rd_b_data (rd_b_data)
  );

  lft_resp_ctrl #(.NUM_SECT(NUM_SECT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .frm_ready (frm_ready),
    .frm_word  (frm_word),
    .dec       (dec),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data),
    .pw_we     (pw_we),
    .pw_addr   (pw_addr),
    .pw_data   (pw_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_len   (rsp_len),
    .rsp_bits  (rsp_bits)
  );

endmodule

// File: tb/test_lf_tag_responder.sv
module test_lf_tag_responder;

  localparam int K_NONE = 0, K_SECT = 1, K_INV = 2, K_ECHO = 3;
  localparam int NT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [7:0]  frm_len = '0;
  logic [31:0] frm_word = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [5:0]  rsp_len;
  logic [31:0] rsp_bits;
  logic        pl_we = 1'b0;
  logic [3:0]  pl_addr = '0;
  logic [31:0] pl_data = '0;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [12];
  logic        m_wr = 1'b0;
  logic [2:0]  m_wsec = '0;

  always #10 clk = ~clk;

  lf_tag_responder i_lf_tag_responder (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .frm_word(frm_word), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_len(rsp_len), .rsp_bits(rsp_bits),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data));

  function automatic logic [31:0] secval(int i);
    return (32'h1000_0001 * (i + 1)) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] f10(logic [1:0] c, logic [2:0] s, logic [1:0] cc, logic [2:0] cs);
    return {c, s, cc, cs, 22'b0};
  endfunction

  // [50:43] len, [42:11] leading bits, [10:8] expected kind, [7:4] sector, [3:0] requirement
  function automatic logic [50:0] ent(int len, logic [31:0] b, int kind, int sect, int req);
    return {8'(len), b, 3'(kind), 4'(sect), 4'(req)};
  endfunction

  localparam logic [50:0] TBL [NT] = '{
    ent(5,  32'hC000_0000,     K_SECT, 0, 2),  // R2 identifier request
    ent(5,  32'hC800_0000,     K_NONE, 0, 2),  // R2 wrong pattern
    ent(10, f10(3,2,0,5),      K_SECT, 2, 4),  // R4 read sector 2
    ent(10, f10(3,7,0,0),      K_SECT, 7, 4),  // R4 read top sector number
    ent(10, f10(3,2,0,4),      K_NONE, 0, 3),  // R3 bad complement
    ent(10, f10(1,5,2,2),      K_INV,  5, 5),  // R5 inverted read
    ent(10, f10(0,3,3,4),      K_NONE, 0, 9),  // R9 opcode 00/11
    ent(10, f10(3,3,1,4),      K_NONE, 0, 9),  // R9 opcode pair mismatch
    ent(32, secval(1) ^ 32'h1, K_NONE, 0, 8),  // R8 wrong password
    ent(32, secval(1),         K_SECT, 3, 8),  // R8 right password
    ent(7,  32'hFE00_0000,     K_NONE, 0, 9),  // R9 odd length
    ent(10, f10(2,6,1,1),      K_ECHO, 0, 6),  // R6 write command echo
    ent(5,  32'hC000_0000,     K_SECT, 0, 7),  // R7 other frame keeps writing state
    ent(32, 32'hDEAD_BEEF,     K_NONE, 0, 7),  // R7 data frame stored silently
    ent(10, f10(3,6,0,1),      K_SECT, 6, 7),  // R7 stored value reads back
    ent(32, secval(1),         K_SECT, 3, 7)   // R7 back to idle: password again
  };

  task automatic chk(string req, string what, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(int len, logic [31:0] w);
    @(negedge clk);
    frm_valid = 1'b1;
    frm_len   = 8'(len);
    frm_word  = w;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic expect_rsp(string req, bit v, int len, logic [31:0] b);
    chk(req, "rsp_valid", 40'(rsp_valid), 40'(v));
    if (v) begin
      chk(req, "rsp_len", 40'(rsp_len), 40'(len));
      chk(req, "rsp_bits", 40'(rsp_bits), 40'(b));
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(req, "rsp_valid after take", 40'(rsp_valid), 40'd0);
    end
  endtask

  task automatic preload(int a, logic [31:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = 4'(a); pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    string rq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rsp_valid", 40'(rsp_valid), 40'd0);
    chk("R1", "frm_ready", 40'(frm_ready), 40'd1);
    send(5, 32'hC000_0000);
    expect_rsp("R1", 1, 32, 32'h0);
    send(32, 32'h0);  // idle compare: sector 1 is zero, so sector 3 (zero) answers
    expect_rsp("R1", 1, 32, 32'h0);

    for (int i = 0; i < 12; i++) begin
      model[i] = secval(i);
      preload(i, secval(i));
    end

    for (int t = 0; t < NT; t++) begin
      logic [7:0]  len  = TBL[t][50:43];
      logic [31:0] w    = TBL[t][42:11];
      int          kind = int'(TBL[t][10:8]);
      int          sect = int'(TBL[t][7:4]);
      rq = $sformatf("R%0d", TBL[t][3:0]);
      send(int'(len), w);
      case (kind)
        K_SECT:  expect_rsp(rq, 1, 32, model[sect]);
        K_INV:   expect_rsp(rq, 1, 32, ~model[sect]);
        K_ECHO:  expect_rsp(rq, 1, 10, w & 32'hFFC0_0000);
        default: expect_rsp(rq, 0, 0, 32'h0);
      endcase
      if (kind == K_ECHO) begin
        m_wr = 1'b1;
        m_wsec = w[29:27];
      end else if (len == 8'd32 && m_wr) begin
        model[m_wsec] = w;
        m_wr = 1'b0;
      end
    end

    // R10 back-pressure: reply held, further frame refused
    send(10, f10(3,2,0,5));
    chk("R10", "rsp_valid", 40'(rsp_valid), 40'd1);
    frm_valid = 1'b1; frm_len = 8'd5; frm_word = 32'hC000_0000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", "frm_ready while pending", 40'(frm_ready), 40'd0);
      chk("R10", "held bits", 40'(rsp_bits), 40'(model[2]));
    end
    frm_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    @(negedge clk);
    chk("R10", "refused frame not answered", 40'(rsp_valid), 40'd0);

    // R9 a 64-bit frame leaves a pending write in place
    send(10, f10(2,0,1,7));
    expect_rsp("R6", 1, 10, f10(2,0,1,7));
    send(64, 32'hFFFF_FFFF);
    expect_rsp("R9", 0, 0, 32'h0);
    send(32, 32'h0BAD_F00D);
    expect_rsp("R7", 0, 0, 32'h0);
    send(5, 32'hC000_0000);
    expect_rsp("R9", 1, 32, 32'h0BAD_F00D);

    // R11 preload beyond the bank is ignored; in-range preload lands
    preload(12, 32'hFFFF_FFFF);
    preload(15, 32'hFFFF_FFFF);
    send(10, f10(3,4,0,3));
    expect_rsp("R11", 1, 32, model[4]);
    send(10, f10(3,7,0,0));
    expect_rsp("R11", 1, 32, model[7]);
    preload(4, 32'h1234_5678);
    send(10, f10(3,4,0,3));
    expect_rsp("R11", 1, 32, 32'h1234_5678);

    finish_run();
  end

endmodule